// File: doc/BRIEF.md
# Pipelined Biquad Cascade with Input Extrapolation

This block is a fixed-point low-pass signal chain built from three cascaded second-order IIR sections. It runs on a sample strobe. The strobe comes from outside the block, and all arithmetic is integer. Samples are signed Q1.15. Coefficients are signed Q2.14. Each section sums its products in a 32-bit signed accumulator, and the scaled result is saturated back to 16 bits.

A mode input selects how the sections work together.

- **Sequential mode:** each section filters the output its predecessor produced for the same sample, so the three sections finish one after another.
- **Parallel mode:** all sections update in the same clock cycle. No section waits for its predecessor. Instead, each section after the first forms a second-order extrapolation of its input from the predecessor's last three outputs and filters that estimate. This removes the one-sample latency between stages.

The first section's input is either an external sample or an internal test source. The test source adds two digital resonators, one near 1 kHz and one near 3.5 kHz at the nominal 15 µs sample period.

The control is a small state machine with three states:

- **ST_IDLE** waits for the strobe.
- **ST_SEQ** steps a section index from 0 to the last section, enabling one section per cycle.
- **ST_PAR** enables every section for one cycle.

Its transitions are:

- **T_START_SEQ:** ST_IDLE to ST_SEQ, on a strobe while the mode is sequential.
- **T_START_PAR:** ST_IDLE to ST_PAR, on a strobe while the mode is parallel.
- **T_STEP:** ST_SEQ to ST_SEQ, while the index is below the last section.
- **T_SEQ_DONE:** ST_SEQ to ST_IDLE, at the last section.
- **T_PAR_DONE:** ST_PAR to ST_IDLE, always.

Top module: `biquad_chain_xtrap`

## Requirements
- R1: While reset is low and right after it, `y_out` is 0 and `out_vld` is 0. All section histories are zero and the test source restarts at its initial state.
- R2: Each section computes acc = b0·x + b1·x1 + b2·x2 − a1·y1 − a2·y2. The sum wraps in 32 bits. The output is acc shifted right arithmetically by 14 and then saturated to 16 bits. Section s, coefficient k sits at `coef_i[(5s+k)*16 +: 16]`, with k = 0 b0, 1 b1, 2 b2, 3 a1, 4 a2. The a-terms are stored with their own sign and are subtracted.
- R3: With `mode_par`=0, section k>0 consumes the output section k−1 produced for the same sample. With all sections set to b0=16384 and the rest 0, `y_out` equals the input sample. `y_out` settles by the fourth rising edge after the strobe edge.
- R4: With `mode_par`=1, all sections update in one cycle. Section k>0 takes sat16(3p(n−1) − 3p(n−2) + p(n−3)), where p is section k−1's output history. With unity pass-through coefficients and a constant input of 100 after reset, the outputs are 0, 0, 900, −900, 600, 0, 100, 100.
- R5: In parallel mode with pass-through coefficients and a ramp input 100·n, the output equals 100·n from sample 6 on.
- R6: `out_vld` goes to 1 once three samples have been processed since reset and stays at 1 until reset.
- R7: A strobe that arrives while the state machine is not in ST_IDLE is ignored. `y_out` changes only when a section step completes.
- R8: With `src_tone`=1 the first section's input is the test source; with 0 it is `ext_smp`, captured at the accepted strobe. The test source adds two resonators. Each resonator runs y = sat16(((K·y1)>>>14) − y2), with K of 32623 and 31001 and initial (y1, y2) of (1388, 0) and (4777, 0). Sample n uses the current y1 values, and the resonators advance once per accepted strobe.
- R9: A section result beyond the 16-bit range saturates. b0=32767 with inputs ±30000 gives 32767 and −32768.
- R10: Run the test source through the nominal coefficient set. The mean squared difference per sample between parallel and sequential outputs, in full-scale units and after 20 samples of settling, stays below 2e-3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_stb | input | 1 | Sample strobe, one cycle |
| mode_par | input | 1 | 1 selects parallel extrapolated mode, 0 selects sequential mode |
| src_tone | input | 1 | 1 selects the internal two-tone source |
| ext_smp | input | 16 | External Q1.15 sample |
| coef_i | input | 240 | Packed Q2.14 coefficients, 5 per section |
| y_out | output | 16 | Last section's output, Q1.15 |
| out_vld | output | 1 | Three samples processed since reset |

## Verification
The bench builds the block with its defaults:

- 16-bit samples and coefficients,
- a 32-bit accumulator,
- 14 fraction bits,
- three sections.

These values put the full signed sample range within reach, so both saturation rails and the wrap-free product path can be driven directly. With three sections the parallel transient lasts several samples, so the extrapolation of an already extrapolated input becomes visible at the output. With pass-through coefficients the step and ramp responses can be worked out by hand. With the nominal coefficients the test source exercises the resonators and the comparison between the two modes.

// File: rtl/biquad_pkg.sv
package biquad_pkg;
    typedef enum logic [1:0] {ST_IDLE, ST_SEQ, ST_PAR} chain_st_t;
    localparam int NCOEF = 5;
endpackage

// File: rtl/fx_sat.sv
module fx_sat #(
    parameter int IW = 32,
    parameter int OW = 16
) (
    input  logic signed [IW-1:0] din,
    output logic signed [OW-1:0] dout
);
    localparam logic signed [IW-1:0] HI = {{(IW-OW+1){1'b0}}, {(OW-1){1'b1}}};
    localparam logic signed [IW-1:0] LO = ~HI;

    always_comb begin
        if (din > HI)      dout = HI[OW-1:0];
        else if (din < LO) dout = LO[OW-1:0];
        else               dout = din[OW-1:0];
    end
endmodule

// File: rtl/tone_src.sv
module tone_src #(
    parameter int W      = 16,
    parameter int AW     = 32,
    parameter int FRAC   = 14,
    parameter int K_A    = 32623,
    parameter int K_B    = 31001,
    parameter int INIT_A = 1388,
    parameter int INIT_B = 4777
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                adv,
    output logic signed [W-1:0] smp
);
    localparam logic signed [AW-1:0] KAW = AW'(K_A);
    localparam logic signed [AW-1:0] KBW = AW'(K_B);

    logic signed [W-1:0]  ra1, ra2, rb1, rb2, na, nb;
    logic signed [AW-1:0] pa, pb, sum;

    always_comb begin
        pa  = ((KAW * AW'(ra1)) >>> FRAC) - AW'(ra2);
        pb  = ((KBW * AW'(rb1)) >>> FRAC) - AW'(rb2);
        sum = AW'(ra1) + AW'(rb1);
    end

    fx_sat #(.IW(AW), .OW(W)) u_sat_a (.din(pa),  .dout(na));
    fx_sat #(.IW(AW), .OW(W)) u_sat_b (.din(pb),  .dout(nb));
    fx_sat #(.IW(AW), .OW(W)) u_sat_o (.din(sum), .dout(smp));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ra1 <= W'(INIT_A);
            ra2 <= '0;
            rb1 <= W'(INIT_B);
            rb2 <= '0;
        end else if (adv) begin
            ra1 <= na;
            ra2 <= ra1;
            rb1 <= nb;
            rb2 <= rb1;
        end
    end
endmodule

// File: rtl/biquad_sec.sv
module biquad_sec
    import biquad_pkg::*;
#(
    parameter int W    = 16,
    parameter int CW   = 16,
    parameter int AW   = 32,
    parameter int FRAC = 14
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   en,
    input  logic signed [W-1:0]    x_in,
    input  logic [NCOEF*CW-1:0]    coef,
    output logic signed [W-1:0]    y1,
    output logic signed [W-1:0]    y2,
    output logic signed [W-1:0]    y3
);
    logic signed [CW-1:0] c [NCOEF];
    logic signed [W-1:0]  xh1, xh2, y_new;
    logic signed [AW-1:0] acc, sh;

    always_comb begin
        for (int k = 0; k < NCOEF; k++) c[k] = coef[k*CW +: CW];
        acc = AW'(c[0]) * AW'(x_in)
            + AW'(c[1]) * AW'(xh1)
            + AW'(c[2]) * AW'(xh2)
            - AW'(c[3]) * AW'(y1)
            - AW'(c[4]) * AW'(y2);
        sh  = acc >>> FRAC;
    end

    fx_sat #(.IW(AW), .OW(W)) u_sat (.din(sh), .dout(y_new));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xh1 <= '0;
            xh2 <= '0;
            y1  <= '0;
            y2  <= '0;
            y3  <= '0;
        end else if (en) begin
            xh1 <= x_in;
            xh2 <= xh1;
            y1  <= y_new;
            y2  <= y1;
            y3  <= y2;
        end
    end
endmodule

// File: rtl/biquad_chain_xtrap.sv
module biquad_chain_xtrap
    import biquad_pkg::*;
#(
    parameter int W      = 16,
    parameter int CW     = 16,
    parameter int AW     = 32,
    parameter int FRAC   = 14,
    parameter int NSEC   = 3,
    parameter int K_A    = 32623,
    parameter int K_B    = 31001,
    parameter int INIT_A = 1388,
    parameter int INIT_B = 4777
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     smp_stb,
    input  logic                     mode_par,
    input  logic                     src_tone,
    input  logic signed [W-1:0]      ext_smp,
    input  logic [NSEC*NCOEF*CW-1:0] coef_i,
    output logic signed [W-1:0]      y_out,
    output logic                     out_vld
);
    localparam int IXW = (NSEC > 1) ? $clog2(NSEC) : 1;
    localparam int CNW = $clog2(NSEC + 1);
    localparam logic [IXW-1:0] LAST = IXW'(NSEC - 1);
    localparam logic [CNW-1:0] VLD  = CNW'(NSEC);

    chain_st_t           st, st_nx;
    logic [IXW-1:0]      seq_idx;
    logic [CNW-1:0]      cnt;
    logic signed [W-1:0] src_q, tone_smp;
    logic                tone_adv;
    logic [NSEC-1:0]     sec_en;
    logic signed [W-1:0] sec_x [NSEC];
    logic signed [W-1:0] y1s [NSEC];
    logic signed [W-1:0] y2s [NSEC];
    logic signed [W-1:0] y3s [NSEC];

    assign tone_adv = (st == ST_IDLE) && smp_stb;

    tone_src #(
        .W(W), .AW(AW), .FRAC(FRAC), .K_A(K_A), .K_B(K_B),
        .INIT_A(INIT_A), .INIT_B(INIT_B)
    ) u_tone (
        .clk(clk), .rst_n(rst_n), .adv(tone_adv), .smp(tone_smp)
    );

    // state register and sample-level bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            seq_idx <= '0;
            src_q   <= '0;
            cnt     <= '0;
        end else begin
            st <= st_nx;
            if (st == ST_SEQ) seq_idx <= seq_idx + 1'b1;
            else              seq_idx <= '0;
            if (tone_adv) src_q <= src_tone ? tone_smp : ext_smp;
            if (st != ST_IDLE && st_nx == ST_IDLE && cnt != VLD) cnt <= cnt + 1'b1;
        end
    end

    // next state
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE: if (smp_stb) st_nx = mode_par ? ST_PAR : ST_SEQ;
            ST_SEQ:  if (seq_idx == LAST) st_nx = ST_IDLE;
            ST_PAR:  st_nx = ST_IDLE;
            default: st_nx = ST_IDLE;
        endcase
    end

    // per-section outputs of the state machine: enable and input routing
    for (genvar k = 0; k < NSEC; k++) begin : g_sec
        always_comb begin
            sec_en[k] = (st == ST_PAR) || ((st == ST_SEQ) && (seq_idx == IXW'(k)));
        end

        if (k == 0) begin : g_head
            assign sec_x[k] = src_q;
        end else begin : g_tail
            logic signed [AW-1:0] pa, pb, pc, est;
            logic signed [W-1:0]  est_s;
            always_comb begin
                pa  = AW'(y1s[k-1]);
                pb  = AW'(y2s[k-1]);
                pc  = AW'(y3s[k-1]);
                est = (pa <<< 1) + pa - ((pb <<< 1) + pb) + pc;
            end
            fx_sat #(.IW(AW), .OW(W)) u_sat (.din(est), .dout(est_s));
            assign sec_x[k] = (st == ST_PAR) ? est_s : y1s[k-1];
        end

        biquad_sec #(.W(W), .CW(CW), .AW(AW), .FRAC(FRAC)) u_sec (
            .clk(clk),
            .rst_n(rst_n),
            .en(sec_en[k]),
            .x_in(sec_x[k]),
            .coef(coef_i[k*NCOEF*CW +: NCOEF*CW]),
            .y1(y1s[k]),
            .y2(y2s[k]),
            .y3(y3s[k])
        );
    end

    assign y_out   = y1s[NSEC-1];
    assign out_vld = (cnt == VLD);
endmodule

// File: rtl/biquad_chain_chk.sv
module biquad_chain_chk
    import biquad_pkg::*;
#(
    parameter int W    = 16,
    parameter int NSEC = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic                smp_stb,
    input logic                mode_par,
    input chain_st_t           st,
    input logic [NSEC-1:0]     sec_en,
    input logic signed [W-1:0] y_out,
    input logic                out_vld
);
    // R3: a strobe in sequential mode starts the section walk
    p_seq_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && smp_stb && !mode_par) |=> (st == ST_SEQ));

    // R3: exactly one section steps per sequential cycle
    p_seq_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SEQ) |-> ($countones(sec_en) == 1));

    // R4: a strobe in parallel mode updates all sections in a single cycle
    p_par_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && smp_stb && mode_par) |=> (st == ST_PAR));

    p_par_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PAR) |=> (st == ST_IDLE));

    // R6: valid, once raised, stays raised until reset
    p_vld_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |=> out_vld);

    // R7: output holds while no section work is finishing
    p_out_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && $past(st) == ST_IDLE) |-> $stable(y_out));

    // R7: idle means no section is enabled
    p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> ($countones(sec_en) == 0));
endmodule

bind biquad_chain_xtrap biquad_chain_chk #(.W(W), .NSEC(NSEC)) u_chk (
    .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .mode_par(mode_par),
    .st(st), .sec_en(sec_en), .y_out(y_out), .out_vld(out_vld)
);

// File: tb/biquad_chain_xtrap_tb.sv
`timescale 1ns/1ps
module biquad_chain_xtrap_tb_top;
    localparam int NS = 3;
    localparam int NC = NS * 5;
    localparam int NT = 150;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 smp_stb = 1'b0;
    logic                 mode_par = 1'b0;
    logic                 src_tone = 1'b0;
    logic signed [15:0]   ext_smp = '0;
    logic [NC*16-1:0]     coef_i = '0;
    logic signed [15:0]   y_out;
    logic                 out_vld;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;
    int cf [NC];

    // model state
    int m_x1 [NS], m_x2 [NS], m_y1 [NS], m_y2 [NS], m_y3 [NS];
    int ta1, ta2, tb1, tb2;
    int rec_ex [NT];
    int rec_pa [NT];

    localparam int TV_N = 8;
    localparam int TV_IN  [TV_N] = '{0, 1000, -1000, 32767, -32768, 12345, -2, 7};
    localparam int TV_EXP [TV_N] = '{0, 1000, -1000, 32767, -32768, 12345, -2, 7};
    localparam int STEP_EXP [8] = '{0, 0, 900, -900, 600, 0, 100, 100};

    biquad_chain_xtrap dut_i (
        .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .mode_par(mode_par),
        .src_tone(src_tone), .ext_smp(ext_smp), .coef_i(coef_i),
        .y_out(y_out), .out_vld(out_vld)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int sat16(input int v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    task automatic load_coefs();
        for (int i = 0; i < NC; i++) coef_i[i*16 +: 16] = cf[i][15:0];
    endtask

    task automatic set_pass();
        for (int i = 0; i < NC; i++) cf[i] = ((i % 5) == 0) ? 16384 : 0;
        load_coefs();
    endtask

    task automatic set_nominal();
        cf = '{8724, -15181, 7223, -31361, 15744,
               5811, -9750, 4635, -29871, 14183,
               3714, -6198, 3275, -26888, 11279};
        load_coefs();
    endtask

    task automatic mdl_reset();
        for (int k = 0; k < NS; k++) begin
            m_x1[k] = 0; m_x2[k] = 0; m_y1[k] = 0; m_y2[k] = 0; m_y3[k] = 0;
        end
        ta1 = 1388; ta2 = 0; tb1 = 4777; tb2 = 0;
    endtask

    function automatic int sec_calc(input int s, input int x);
        int acc;
        acc = cf[s*5] * x + cf[s*5+1] * m_x1[s] + cf[s*5+2] * m_x2[s]
            - cf[s*5+3] * m_y1[s] - cf[s*5+4] * m_y2[s];
        return sat16(acc >>> 14);
    endfunction

    task automatic sec_push(input int s, input int x, input int y);
        m_x2[s] = m_x1[s]; m_x1[s] = x;
        m_y3[s] = m_y2[s]; m_y2[s] = m_y1[s]; m_y1[s] = y;
    endtask

    task automatic mdl_tone(output int v);
        int na, nb;
        v  = sat16(ta1 + tb1);
        na = sat16(((32623 * ta1) >>> 14) - ta2);
        nb = sat16(((31001 * tb1) >>> 14) - tb2);
        ta2 = ta1; ta1 = na; tb2 = tb1; tb1 = nb;
    endtask

    task automatic mdl_step(input int src, input bit par, output int yo);
        int xin [NS];
        int yn [NS];
        if (par) begin
            xin[0] = src;
            for (int k = 1; k < NS; k++)
                xin[k] = sat16(3*m_y1[k-1] - 3*m_y2[k-1] + m_y3[k-1]);
            for (int k = 0; k < NS; k++) yn[k] = sec_calc(k, xin[k]);
            for (int k = 0; k < NS; k++) sec_push(k, xin[k], yn[k]);
        end else begin
            for (int k = 0; k < NS; k++) begin
                xin[k] = (k == 0) ? src : m_y1[k-1];
                yn[k]  = sec_calc(k, xin[k]);
                sec_push(k, xin[k], yn[k]);
            end
        end
        yo = m_y1[NS-1];
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        mdl_reset();
    endtask

    task automatic do_sample(input int x, input int hold);
        @(negedge clk);
        ext_smp = x[15:0];
        smp_stb = 1'b1;
        repeat (hold) @(negedge clk);
        smp_stb = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int yo, src;
        real acc, d, mse;
        set_pass();
        do_reset();
        chk("R1 y_out after reset", int'(y_out), 0);
        chk("R1 out_vld after reset", int'(out_vld), 0);

        // table walk: sequential pass-through
        mode_par = 1'b0; src_tone = 1'b0;
        for (int i = 0; i < TV_N; i++) begin
            do_sample(TV_IN[i], 1);
            chk("R3 pass-through table", int'(y_out), TV_EXP[i]);
            if (i < 3) chk("R6 valid after samples", int'(out_vld), (i == 2) ? 1 : 0);
        end
        chk("R6 valid held", int'(out_vld), 1);

        do_reset();
        chk("R1 y_out cleared by reset", int'(y_out), 0);
        chk("R1 out_vld cleared by reset", int'(out_vld), 0);

        // parallel step response
        mode_par = 1'b1;
        for (int i = 0; i < 8; i++) begin
            do_sample(100, 1);
            chk("R4 parallel step", int'(y_out), STEP_EXP[i]);
        end

        // parallel ramp
        do_reset();
        for (int i = 0; i < 12; i++) begin
            do_sample(100 * i, 1);
            if (i >= 6) chk("R5 ramp tracked", int'(y_out), 100 * i);
        end

        // saturation
        do_reset();
        mode_par = 1'b0;
        cf[0] = 32767; load_coefs();
        do_sample(30000, 1);
        chk("R9 saturate high", int'(y_out), 32767);
        do_sample(-30000, 1);
        chk("R9 saturate low", int'(y_out), -32768);
        set_pass();

        // strobes during busy ignored
        do_reset();
        do_sample(500, 2);
        do_sample(600, 2);
        chk("R7 busy strobe ignored (valid)", int'(out_vld), 0);
        chk("R7 busy strobe ignored (value)", int'(y_out), 600);
        do_sample(700, 1);
        chk("R7 third accepted strobe", int'(out_vld), 1);
        chk("R7 third value", int'(y_out), 700);

        // test source through nominal chain, both modes
        set_nominal();
        src_tone = 1'b1;
        mode_par = 1'b0;
        do_reset();
        for (int i = 0; i < NT; i++) begin
            mdl_tone(src);
            mdl_step(src, 1'b0, yo);
            do_sample(0, 1);
            chk("R8 R2 R3 tone sequential", int'(y_out), yo);
            rec_ex[i] = int'(y_out);
        end
        mode_par = 1'b1;
        do_reset();
        for (int i = 0; i < NT; i++) begin
            mdl_tone(src);
            mdl_step(src, 1'b1, yo);
            do_sample(0, 1);
            chk("R8 R4 tone parallel", int'(y_out), yo);
            rec_pa[i] = int'(y_out);
        end
        acc = 0.0;
        for (int i = 20; i < NT; i++) begin
            d = real'(rec_ex[i] - rec_pa[i]) / 32768.0;
            acc += d * d;
        end
        mse = acc / real'(NT - 20);
        n_chk++;
        if (!(mse < 2.0e-3)) begin
            n_bad++;
            $display("FAIL R10 mse actual=%g expected=<%g", mse, 2.0e-3);
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule